// File: doc/BRIEF.md
# Watchdog and System Register Block

This block is a small byte-wide register file that sits on a host I/O bus and gathers board-level status, identification, indicator controls and a software-serviced watchdog timer. The host reads and writes 8-bit registers at 5-bit offsets. Read data is registered and appears one cycle after the read strobe. Writes take effect on the clock edge at which the write strobe is sampled.

The watchdog counts ticks from an internal prescaler. Software restarts the count by changing the trigger bit in the control register. If the count expires, the block either raises a fixed-length hardware reset request or a single-cycle NMI request, as the control register selects. Expiry also clears a sticky active-low timeout flag in the status register. An ordinary system reset leaves this flag untouched, so software can tell after restart that the watchdog caused the reset. The flag is set back to 1 only by a power-on reset or by writing one of two magic bytes to the option ID offset. One magic byte requests a hardware reset and the other requests a power cycle. If software enables the watchdog while the flag is still low, the selected action fires again at once. A lock bit, once set, keeps an enabled watchdog from being disabled.

Top module: `sysreg_block`

## Requirements
- R1: Offset 2 reads 51h and offset 4 reads D0h. Offset 6 reads the REV_ID parameter. Offsets 7, 8, 9 and 0Eh..1Fh read 00h. Writes to any of these read-only offsets leave the values read unchanged. Read data is captured on the edge where `bus_rd` is sampled high.
- R2: Offset 0 (status) reads {ovr_temp_n, low_bat_n, 1, timeout flag, 1, 1, bus_err_n, pwr_fail_n} from bit 7 down to bit 0. It reads FFh after power-on with all inputs high. Writes to it are ignored.
- R3: Offset 1 (control) resets to 05h. Bits 7:4 are read/write. Bit 6 is the watchdog trigger, bit 5 selects the NMI action (1) or the reset action (0), and bit 4 drives `stop_out`. Bits 3:0 always read 0101b.
- R4: Offset 3 (watchdog configuration) resets to {LOCK_RST, 7'b0}. Bits 6:4 read 0 and bits 3:0 hold a timeout code. A non-zero code is used as is. A code of 0 takes the code from `cfg_sw`.
- R5: Offset 5 (setup) resets to 07h. Bit 7 drives `ready_led`, bit 6 is the watchdog enable, bit 5 drives `aux_led`, and bits 2:0 drive `pwr_en`. Bits 4:3 read 0.
- R6: With effective code n, the watchdog expires after 2^n ticks, counted from the cycle it is enabled or triggered. One tick occurs every TICK_DIV clocks.
- R7: Any write to offset 1 that changes bit 6 restarts the watchdog count. While such toggles keep arriving faster than the period, the watchdog never expires.
- R8: In reset mode, expiry raises `hw_rst_req` for exactly RST_LEN (16) clocks. In NMI mode, expiry raises `nmi_req` for exactly one clock. Only one action fires per expiry, and the expired watchdog stays quiet afterwards.
- R9: Expiry drives status bit 4 to 0. The bit stays 0 through `sys_rst_n`. Only `por_n` or a magic write returns it to 1.
- R10: Writing A5h to offset 4 sets the timeout flag to 1 and raises `hw_rst_req` for RST_LEN clocks. Writing 5Ah to offset 4 sets the flag to 1 and raises `pwr_cycle_req` for RST_LEN clocks. Any other value written to offset 4 has no effect.
- R11: Enabling the watchdog (setup bit 6 going 0 to 1) while the timeout flag is 0 fires the selected action on the next cycle.
- R12: Writing 1 to configuration bit 7 sets the lock, and only a reset clears it. While the lock is set and the watchdog is enabled, a setup write with bit 6 = 0 leaves the enable at 1. Without the lock, such a write disables the watchdog.
- R13: Offset 0Ah reads {6'b0, boot_mode}. Offset 0Ch reads {4'b0, cfg_sw}. Offset 0Bh reads {scl_o, sda_o, i2c_scl_in, i2c_sda_in, 4'hF}, and a write to it sets scl_o and sda_o from bits 7 and 6. Offset 0Dh is a read/write PWM preset that resets to FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; also resets the timeout flag and pulse generators |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; resets registers only |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_sw | input | 4 | Configuration switch, fallback timeout code |
| boot_mode | input | 2 | Boot mode inputs |
| ovr_temp_n | input | 1 | Over-temperature, active low |
| low_bat_n | input | 1 | Low battery, active low |
| bus_err_n | input | 1 | Expansion bus error, active low |
| pwr_fail_n | input | 1 | Power fail, active low |
| i2c_scl_in | input | 1 | Sensed I2C clock line |
| i2c_sda_in | input | 1 | Sensed I2C data line |
| i2c_scl_o | output | 1 | I2C clock output latch |
| i2c_sda_o | output | 1 | I2C data output latch |
| hw_rst_req | output | 1 | Hardware reset request pulse |
| nmi_req | output | 1 | NMI request pulse |
| pwr_cycle_req | output | 1 | Power-cycle request pulse |
| ready_led | output | 1 | Ready indicator |
| aux_led | output | 1 | Auxiliary indicator |
| stop_out | output | 1 | Add-on stop control, control bit 4 |
| pwr_en | output | 3 | Port power enables |
| pwm_preset | output | 8 | Brightness PWM preset |

## Verification
On every cycle, the assertions check these properties:
- the NMI request is never longer than one cycle;
- each reset-request pulse lasts exactly RST_LEN clocks;
- the timeout flag rises only after a magic write and falls after an expiry;
- a power-cycle request follows its magic byte;
- enabling with the flag low re-fires at once;
- a locked, enabled watchdog cannot be disabled, and the lock never drops outside reset.

Only the bench scenarios can show the following:
- the expiry latency of 2^n ticks, for both a register code and a switch code;
- a stream of trigger toggles holding off expiry;
- the flag surviving a system reset;
- the register map, its constant bits and its ignored writes.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam logic [7:0] FUNC_ID_VAL  = 8'h51;
  localparam logic [7:0] OPT_ID_VAL   = 8'hD0;
  localparam logic [7:0] MAGIC_HWRST  = 8'hA5;
  localparam logic [7:0] MAGIC_PWRCYC = 8'h5A;

  localparam int WD_CODE_W = 4;
  localparam int WD_CNT_W  = 16;

  typedef enum logic [4:0] {
    OFF_STAT  = 5'h00,
    OFF_CTRL  = 5'h01,
    OFF_FID   = 5'h02,
    OFF_WDCFG = 5'h03,
    OFF_OID   = 5'h04,
    OFF_SETUP = 5'h05,
    OFF_REV   = 5'h06,
    OFF_BOOT  = 5'h0A,
    OFF_I2C   = 5'h0B,
    OFF_SW    = 5'h0C,
    OFF_PWM   = 5'h0D
  } reg_off_e;

  // Effective timeout code: register code unless zero, then the switch.
  function automatic logic [WD_CODE_W-1:0] wd_code_sel(
    input logic [WD_CODE_W-1:0] cfg_code,
    input logic [WD_CODE_W-1:0] sw_code);
    return (cfg_code != '0) ? cfg_code : sw_code;
  endfunction

  // Terminal tick count for a period of 2^code ticks.
  function automatic logic [WD_CNT_W-1:0] wd_limit(input logic [WD_CODE_W-1:0] code);
    return (WD_CNT_W'(1) << code) - WD_CNT_W'(1);
  endfunction

endpackage

// File: rtl/sysreg_tick_div.sv
module sysreg_tick_div #(
  parameter int TICK_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               div_cnt <= '0;
    else if (div_cnt == LAST) div_cnt <= '0;
    else                      div_cnt <= div_cnt + 1'b1;
  end

  assign tick = (div_cnt == LAST);
endmodule

// File: rtl/sysreg_regs.sv
module sysreg_regs
  import sysreg_pkg::*;
#(
  parameter logic       LOCK_RST = 1'b1,
  parameter logic [7:0] REV_ID   = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [3:0] cfg_sw,
  input  logic [1:0] boot_mode,
  input  logic       ovr_temp_n,
  input  logic       low_bat_n,
  input  logic       bus_err_n,
  input  logic       pwr_fail_n,
  input  logic       i2c_scl_in,
  input  logic       i2c_sda_in,
  input  logic       flag_n,
  output logic       wden,
  output logic       lock,
  output logic       nmi_mode,
  output logic [3:0] tmo_code,
  output logic       trig_evt,
  output logic       magic_rst,
  output logic       magic_pwr,
  output logic       setup_wr,
  output logic       ready_led,
  output logic       aux_led,
  output logic       stop_out,
  output logic [2:0] pwr_en,
  output logic       i2c_scl_o,
  output logic       i2c_sda_o,
  output logic [7:0] pwm_preset
);
  logic [3:0] ctrl_hi;   // trig-bus, wd trigger, nmi select, stop
  logic [3:0] tout;
  logic [7:0] rd_mux;
  logic       wr_ctrl, wr_oid;

  assign wr_ctrl  = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_oid   = bus_wr && (bus_addr == OFF_OID);
  assign setup_wr = bus_wr && (bus_addr == OFF_SETUP);

  assign trig_evt  = wr_ctrl && (bus_wdata[6] != ctrl_hi[2]);
  assign magic_rst = wr_oid && (bus_wdata == MAGIC_HWRST);
  assign magic_pwr = wr_oid && (bus_wdata == MAGIC_PWRCYC);

  assign nmi_mode = ctrl_hi[1];
  assign stop_out = ctrl_hi[0];
  assign tmo_code = wd_code_sel(tout, cfg_sw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_hi    <= 4'b0000;
      lock       <= LOCK_RST;
      tout       <= '0;
      ready_led  <= 1'b0;
      wden       <= 1'b0;
      aux_led    <= 1'b0;
      pwr_en     <= 3'b111;
      i2c_scl_o  <= 1'b1;
      i2c_sda_o  <= 1'b1;
      pwm_preset <= 8'hFF;
    end else if (bus_wr) begin
      case (bus_addr)
        OFF_CTRL:  ctrl_hi <= bus_wdata[7:4];
        OFF_WDCFG: begin
          lock <= lock | bus_wdata[7];
          tout <= bus_wdata[3:0];
        end
        OFF_SETUP: begin
          ready_led <= bus_wdata[7];
          wden      <= bus_wdata[6] | (lock & wden);
          aux_led   <= bus_wdata[5];
          pwr_en    <= bus_wdata[2:0];
        end
        OFF_I2C: begin
          i2c_scl_o <= bus_wdata[7];
          i2c_sda_o <= bus_wdata[6];
        end
        OFF_PWM:   pwm_preset <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_STAT:  rd_mux = {ovr_temp_n, low_bat_n, 1'b1, flag_n, 2'b11, bus_err_n, pwr_fail_n};
      OFF_CTRL:  rd_mux = {ctrl_hi, 4'b0101};
      OFF_FID:   rd_mux = FUNC_ID_VAL;
      OFF_WDCFG: rd_mux = {lock, 3'b000, tout};
      OFF_OID:   rd_mux = OPT_ID_VAL;
      OFF_SETUP: rd_mux = {ready_led, wden, aux_led, 2'b00, pwr_en};
      OFF_REV:   rd_mux = REV_ID;
      OFF_BOOT:  rd_mux = {6'b0, boot_mode};
      OFF_I2C:   rd_mux = {i2c_scl_o, i2c_sda_o, i2c_scl_in, i2c_sda_in, 4'hF};
      OFF_SW:    rd_mux = {4'b0, cfg_sw};
      OFF_PWM:   rd_mux = pwm_preset;
      default:   rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/sysreg_wdt_core.sv
module sysreg_wdt_core
  import sysreg_pkg::*;
#(
  parameter int RST_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       tick,
  input  logic       wden,
  input  logic       trig_evt,
  input  logic [3:0] tmo_code,
  input  logic       nmi_mode,
  input  logic       magic_rst,
  input  logic       magic_pwr,
  output logic       flag_n,
  output logic       wd_timeout,
  output logic       wd_fire,
  output logic       hw_rst_req,
  output logic       nmi_req,
  output logic       pwr_cycle_req
);
  localparam int PW = $clog2(RST_LEN + 1);
  localparam logic [PW-1:0] PLEN = PW'(RST_LEN);

  logic [WD_CNT_W-1:0] cnt;
  logic                wden_q, start, running, refire, at_limit;
  logic [PW-1:0]       rst_cnt, pwr_cnt;

  assign start    = wden && !wden_q;
  assign running  = wden && flag_n;
  assign at_limit = (cnt == wd_limit(tmo_code));

  assign wd_timeout = running && tick && at_limit && !start && !trig_evt;
  assign refire     = start && !flag_n;
  assign wd_fire    = wd_timeout || refire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wden_q <= 1'b0;
      cnt    <= '0;
    end else begin
      wden_q <= wden;
      if (start || trig_evt || !running) cnt <= '0;
      else if (tick)                     cnt <= at_limit ? '0 : cnt + 1'b1;
    end
  end

  // Sticky flag and request pulses live in the power-on domain only.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flag_n  <= 1'b1;
      nmi_req <= 1'b0;
      rst_cnt <= '0;
      pwr_cnt <= '0;
    end else begin
      if (magic_rst || magic_pwr) flag_n <= 1'b1;
      else if (wd_timeout)        flag_n <= 1'b0;

      nmi_req <= wd_fire && nmi_mode;

      if ((wd_fire && !nmi_mode) || magic_rst) rst_cnt <= PLEN;
      else if (rst_cnt != '0)                  rst_cnt <= rst_cnt - 1'b1;

      if (magic_pwr)          pwr_cnt <= PLEN;
      else if (pwr_cnt != '0) pwr_cnt <= pwr_cnt - 1'b1;
    end
  end

  assign hw_rst_req    = (rst_cnt != '0);
  assign pwr_cycle_req = (pwr_cnt != '0);
endmodule

// File: rtl/sysreg_block.sv
module sysreg_block
  import sysreg_pkg::*;
#(
  parameter int         TICK_DIV = 1000,
  parameter int         RST_LEN  = 16,
  parameter logic       LOCK_RST = 1'b1,
  parameter logic [7:0] REV_ID   = 8'h01
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       sys_rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [3:0] cfg_sw,
  input  logic [1:0] boot_mode,
  input  logic       ovr_temp_n,
  input  logic       low_bat_n,
  input  logic       bus_err_n,
  input  logic       pwr_fail_n,
  input  logic       i2c_scl_in,
  input  logic       i2c_sda_in,
  output logic       i2c_scl_o,
  output logic       i2c_sda_o,
  output logic       hw_rst_req,
  output logic       nmi_req,
  output logic       pwr_cycle_req,
  output logic       ready_led,
  output logic       aux_led,
  output logic       stop_out,
  output logic [2:0] pwr_en,
  output logic [7:0] pwm_preset
);
  logic       rst_n;
  logic       tick;
  logic       wden, lock, nmi_mode, trig_evt, magic_rst, magic_pwr, setup_wr;
  logic [3:0] tmo_code;
  logic       flag_n, wd_timeout, wd_fire;

  assign rst_n = por_n & sys_rst_n;

  sysreg_tick_div #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sysreg_regs #(.LOCK_RST(LOCK_RST), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_sw(cfg_sw), .boot_mode(boot_mode),
    .ovr_temp_n(ovr_temp_n), .low_bat_n(low_bat_n),
    .bus_err_n(bus_err_n), .pwr_fail_n(pwr_fail_n),
    .i2c_scl_in(i2c_scl_in), .i2c_sda_in(i2c_sda_in),
    .flag_n(flag_n),
    .wden(wden), .lock(lock), .nmi_mode(nmi_mode), .tmo_code(tmo_code),
    .trig_evt(trig_evt), .magic_rst(magic_rst), .magic_pwr(magic_pwr),
    .setup_wr(setup_wr),
    .ready_led(ready_led), .aux_led(aux_led), .stop_out(stop_out),
    .pwr_en(pwr_en), .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
    .pwm_preset(pwm_preset)
  );

  sysreg_wdt_core #(.RST_LEN(RST_LEN)) u_wdt (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick),
    .wden(wden), .trig_evt(trig_evt), .tmo_code(tmo_code),
    .nmi_mode(nmi_mode), .magic_rst(magic_rst), .magic_pwr(magic_pwr),
    .flag_n(flag_n), .wd_timeout(wd_timeout), .wd_fire(wd_fire),
    .hw_rst_req(hw_rst_req), .nmi_req(nmi_req),
    .pwr_cycle_req(pwr_cycle_req)
  );
endmodule

// File: rtl/sysreg_block_chk.sv
module sysreg_block_chk #(
  parameter int RST_LEN = 16
) (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       wden,
  input logic       lock,
  input logic       flag_n,
  input logic       wd_timeout,
  input logic       setup_wr,
  input logic [7:0] bus_wdata,
  input logic       magic_rst,
  input logic       magic_pwr,
  input logic       hw_rst_req,
  input logic       nmi_req,
  input logic       pwr_cycle_req
);
  int unsigned hw_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          hw_run <= 0;
    else if (hw_rst_req) hw_run <= hw_run + 1;
    else                 hw_run <= 0;
  end

  // R8
  nmi_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    nmi_req |=> !nmi_req);

  // R8
  rst_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(hw_rst_req) |-> (hw_run == RST_LEN));

  // R9
  flag_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag_n) |-> $past(magic_rst || magic_pwr));

  // R9
  tmo_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wd_timeout && !magic_rst && !magic_pwr) |=> !flag_n);

  // R10
  magic_pwr_chk: assert property (@(posedge clk) disable iff (!por_n)
    magic_pwr |=> pwr_cycle_req);

  // R11
  refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wden) && !flag_n) |=> (nmi_req || hw_rst_req));

  // R12
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wden && setup_wr && !bus_wdata[6]) |=> wden);

  // R12
  lock_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
endmodule

bind sysreg_block sysreg_block_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wden(wden), .lock(lock),
  .flag_n(flag_n), .wd_timeout(wd_timeout), .setup_wr(setup_wr),
  .bus_wdata(bus_wdata), .magic_rst(magic_rst), .magic_pwr(magic_pwr),
  .hw_rst_req(hw_rst_req), .nmi_req(nmi_req), .pwr_cycle_req(pwr_cycle_req)
);

// File: tb/sysreg_block_bench.sv
module sysreg_block_bench;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int PLEN  = 16;
  localparam logic [7:0] REV = 8'h12;

  logic clk = 0, por_n = 0, sys_rst_n = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] cfg_sw = 4'h3;
  logic [1:0] boot_mode = 2'b10;
  logic ovr_temp_n = 1, low_bat_n = 1, bus_err_n = 1, pwr_fail_n = 1;
  logic i2c_scl_in = 1, i2c_sda_in = 1;
  logic i2c_scl_o, i2c_sda_o, hw_rst_req, nmi_req, pwr_cycle_req;
  logic ready_led, aux_led, stop_out;
  logic [2:0] pwr_en;
  logic [7:0] pwm_preset;

  always #(CLK_P/2) clk = ~clk;

  sysreg_block #(.TICK_DIV(DIV), .RST_LEN(PLEN), .LOCK_RST(1'b0), .REV_ID(REV)) u_sysreg_block (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_sw(cfg_sw), .boot_mode(boot_mode),
    .ovr_temp_n(ovr_temp_n), .low_bat_n(low_bat_n),
    .bus_err_n(bus_err_n), .pwr_fail_n(pwr_fail_n),
    .i2c_scl_in(i2c_scl_in), .i2c_sda_in(i2c_sda_in),
    .i2c_scl_o(i2c_scl_o), .i2c_sda_o(i2c_sda_o),
    .hw_rst_req(hw_rst_req), .nmi_req(nmi_req), .pwr_cycle_req(pwr_cycle_req),
    .ready_led(ready_led), .aux_led(aux_led), .stop_out(stop_out),
    .pwr_en(pwr_en), .pwm_preset(pwm_preset)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Pulse monitors, sampled at the falling edge.
  int cyc = 0;
  int hw_rises = 0, nmi_rises = 0, pwr_rises = 0;
  int hw_rise_cyc = 0, nmi_rise_cyc = 0;
  int hw_run = 0, hw_width = 0, pwr_run = 0, pwr_width = 0;
  logic hw_q = 0, nmi_q = 0, pwr_q = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (hw_rst_req && !hw_q) begin hw_rises <= hw_rises + 1; hw_rise_cyc <= cyc; hw_run <= 1; end
    else if (hw_rst_req) hw_run <= hw_run + 1;
    else if (hw_q) hw_width <= hw_run;
    if (nmi_req && !nmi_q) begin nmi_rises <= nmi_rises + 1; nmi_rise_cyc <= cyc; end
    if (pwr_cycle_req && !pwr_q) begin pwr_rises <= pwr_rises + 1; pwr_run <= 1; end
    else if (pwr_cycle_req) pwr_run <= pwr_run + 1;
    else if (pwr_q) pwr_width <= pwr_run;
    hw_q <= hw_rst_req; nmi_q <= nmi_req; pwr_q <= pwr_cycle_req;
  end

  int mark = 0;

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d; mark = cyc;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sys_reset();
    @(negedge clk); sys_rst_n = 0;
    wait_cyc(3);
    sys_rst_n = 1;
    wait_cyc(2);
  endtask

  // {addr, write, wdata, expected read}
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {5'h00, 1'b1, 8'h00, 8'hFF},  // R2 status write ignored
    {5'h01, 1'b1, 8'hF0, 8'hF5},  // R3 upper bits rw
    {5'h01, 1'b1, 8'h0A, 8'h05},  // R3 low nibble constant
    {5'h02, 1'b1, 8'h00, 8'h51},  // R1 function id
    {5'h04, 1'b1, 8'h00, 8'hD0},  // R1 option id
    {5'h06, 1'b1, 8'hFF, REV},    // R1 revision
    {5'h07, 1'b1, 8'hFF, 8'h00},  // R1 reads zero
    {5'h09, 1'b1, 8'hFF, 8'h00},  // R1 reads zero
    {5'h1F, 1'b1, 8'hFF, 8'h00},  // R1 reserved
    {5'h03, 1'b1, 8'h7F, 8'h0F},  // R4 bits 6:4 zero
    {5'h03, 1'b1, 8'h03, 8'h03},  // R4 code
    {5'h05, 1'b1, 8'h9D, 8'h85},  // R5 bits 4:3 zero
    {5'h0A, 1'b0, 8'h00, 8'h02},  // R13 boot mode
    {5'h0C, 1'b0, 8'h00, 8'h03},  // R13 switch
    {5'h0D, 1'b1, 8'h3C, 8'h3C},  // R13 pwm
    {5'h0B, 1'b1, 8'h40, 8'h7F}   // R13 i2c
  };

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0, h0, p0;
    wait_cyc(3);
    por_n = 1;
    wait_cyc(2);

    // Reset state
    chk("R8 reset hw_rst_req", hw_rst_req, 0);
    chk("R8 reset nmi_req", nmi_req, 0);
    rd_chk("R2 reset status", 5'h00, 8'hFF);
    rd_chk("R3 reset control", 5'h01, 8'h05);
    rd_chk("R4 reset wdcfg", 5'h03, 8'h00);
    rd_chk("R5 reset setup", 5'h05, 8'h07);
    rd_chk("R13 reset pwm", 5'h0D, 8'hFF);
    chk("R13 reset pwm port", pwm_preset, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) wr(VEC[i][21:17], VEC[i][15:8]);
      rd_chk($sformatf("R1/R2/R3/R4/R5/R13 vec %0d", i), VEC[i][21:17], VEC[i][7:0]);
    end
    chk("R5 ready_led", ready_led, 1);
    chk("R5 aux_led", aux_led, 0);
    chk("R5 pwr_en", pwr_en, 3'b101);
    chk("R13 scl_o", i2c_scl_o, 0);
    chk("R13 sda_o", i2c_sda_o, 1);
    wr(5'h01, 8'h10);
    chk("R3 stop_out", stop_out, 1);

    // R2 live inputs
    ovr_temp_n = 0; pwr_fail_n = 0;
    rd_chk("R2 status inputs", 5'h00, 8'h7E);
    ovr_temp_n = 1; pwr_fail_n = 1;

    // R6 R8: NMI expiry with code 2
    wr(5'h03, 8'h02); wr(5'h01, 8'h20);
    n0 = nmi_rises;
    wr(5'h05, 8'h40);
    wait_cyc(40);
    chk("R8 one nmi", nmi_rises, n0 + 1);
    chk_rng("R6 period code2", nmi_rise_cyc - mark, 3*DIV, 4*DIV + 4);
    rd_chk("R9 flag low", 5'h00, 8'hEF);
    wait_cyc(60);
    chk("R8 no repeat nmi", nmi_rises, n0 + 1);

    // R9 flag survives system reset
    h0 = hw_rises;
    sys_reset();
    rd_chk("R9 flag after sys reset", 5'h00, 8'hEF);
    rd_chk("R9 setup after sys reset", 5'h05, 8'h07);
    chk("R9 no pulse from sys reset", hw_rises, h0);

    // R11 refire
    wr(5'h01, 8'h20);
    n0 = nmi_rises;
    wr(5'h05, 8'h40);
    wait_cyc(10);
    chk("R11 refire nmi", nmi_rises, n0 + 1);
    chk_rng("R11 refire latency", nmi_rise_cyc - mark, 1, 4);

    // R12 unlocked disable, R10 power-cycle magic
    wr(5'h05, 8'h07);
    rd_chk("R12 unlocked disable", 5'h05, 8'h07);
    h0 = hw_rises; p0 = pwr_rises;
    wr(5'h04, 8'h5A);
    wait_cyc(25);
    chk("R10 pwr pulse", pwr_rises, p0 + 1);
    chk("R10 pwr width", pwr_width, PLEN);
    chk("R10 no hw on 5A", hw_rises, h0);
    rd_chk("R10 flag cleared 5A", 5'h00, 8'hFF);

    // R4 R6 R8 switch code, reset action
    wr(5'h03, 8'h00); wr(5'h01, 8'h00);
    h0 = hw_rises;
    wr(5'h05, 8'h40);
    wait_cyc(60);
    chk("R8 hw pulse", hw_rises, h0 + 1);
    chk_rng("R4 switch period", hw_rise_cyc - mark, 7*DIV, 8*DIV + 4);
    chk("R8 hw width", hw_width, PLEN);
    rd_chk("R9 flag low reset mode", 5'h00, 8'hEF);
    wr(5'h05, 8'h00);
    h0 = hw_rises;
    wr(5'h04, 8'hA5);
    wait_cyc(25);
    chk("R10 A5 hw pulse", hw_rises, h0 + 1);
    chk("R10 A5 width", hw_width, PLEN);
    rd_chk("R10 flag cleared A5", 5'h00, 8'hFF);

    // R7 trigger toggles hold off expiry
    wr(5'h03, 8'h02); wr(5'h01, 8'h20);
    n0 = nmi_rises;
    wr(5'h05, 8'h40);
    for (int k = 0; k < 12; k++) begin
      wr(5'h01, (k % 2 == 0) ? 8'h60 : 8'h20);
      wait_cyc(6);
    end
    chk("R7 no expiry while toggled", nmi_rises, n0);
    wait_cyc(40);
    chk("R7 expiry after toggles stop", nmi_rises, n0 + 1);

    // R12 lock
    wr(5'h03, 8'h82);
    rd_chk("R12 lock set", 5'h03, 8'h82);
    wr(5'h05, 8'h00);
    rd_chk("R12 locked disable ignored", 5'h05, 8'h40);
    wr(5'h03, 8'h02);
    rd_chk("R12 lock not clearable", 5'h03, 8'h82);

    // R10 other value has no effect
    h0 = hw_rises; p0 = pwr_rises;
    wr(5'h04, 8'h12);
    wait_cyc(20);
    chk("R10 other value no hw", hw_rises, h0);
    chk("R10 other value no pwr", pwr_rises, p0);
    rd_chk("R10 other value flag kept", 5'h00, 8'hEF);

    sys_reset();
    rd_chk("R12 lock cleared by reset", 5'h03, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule